// File: doc/BRIEF.md
# I2C SCL Clock Divider Generator

This block derives the serial clock timing of an I2C controller from the system clock. A programmable prescaler divides the system clock into a module-clock tick. Two phase counters then time the SCL low period and the SCL high period in module-clock ticks. Each phase runs for its programmed count plus a fixed extra count that depends on the prescale setting.

The output is a drive request: when it is set, the pad pulls SCL low, and when it is clear, the pad releases SCL. The high phase is not timed until the sampled SCL line reads high, so a slave that holds SCL low stretches the clock. Two single-cycle strobes serve the data logic. One marks the middle of each high phase, where data is sampled. The other marks the first cycle of each low phase that follows a high phase, where data may change.

Divider values are taken into the block while it is disabled, and again at the start of every low phase. A change made in the middle of a period therefore shows up from the next low phase.

Top module: `scl_divgen`

## Requirements
- R1: While reset is asserted, and in the first cycles after reset, scl_drive_low, mid_stb and fall_stb are all 0.
- R2: Both SCL phases last a whole number of module-clock periods. One module-clock period is psc+1 system-clock cycles.
- R3: scl_drive_low stays 1 for exactly (clkl+d)*(psc+1) consecutive cycles in every low phase.
- R4: The extra count d is 7 when psc is 0, 6 when psc is 1, and 5 when psc is 2 or greater.
- R5: After the low phase ends, the high phase begins only at the first clock edge that samples scl_in as 1. The high phase then lasts (clkh+d)*(psc+1) cycles. Without stretching, scl_drive_low is 0 for (clkh+d)*(psc+1)+1 cycles. A slave that holds scl_in low for S extra cycles lengthens this by S.
- R6: A change to psc, clkl or clkh during a period does not alter the low phase or the high phase already in progress. It takes effect from the next low phase.
- R7: When en is sampled 0, scl_drive_low is 0 from the next cycle on, and both strobes are 0. When en is sampled 1 again, a full low phase starts in the next cycle.
- R8: fall_stb is a one-cycle pulse. It is asserted in the first cycle of each low phase that follows a high phase, and it is not asserted for the first low phase after enable.
- R9: mid_stb is a one-cycle pulse. It is asserted in the high-phase cycle that follows floor((clkh+d)/2)*(psc+1) high-phase cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; 0 releases SCL and restarts at a low phase |
| psc | input | CNT_W | Prescale value; module clock = system clock / (psc+1) |
| clkl | input | CNT_W | Low-phase count before the extra count d is added |
| clkh | input | CNT_W | High-phase count before the extra count d is added |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| mid_stb | output | 1 | Pulse at the middle of the high phase |
| fall_stb | output | 1 | Pulse in the first cycle of a low phase that follows a high phase |

## Verification
The bench builds the block with its default 16-bit counter width. It programs prescale values 0, 1 and 3, which reach all three values of the extra count, together with low and high counts small enough that many full periods fit in a short run. A reference model counts the remaining cycles of each phase and is compared on every cycle. The bench also covers a slave stretch of seven cycles, a divider change in the middle of a period, and disabling the block in the middle of a phase.

// File: rtl/scl_divgen.sv
module scl_divgen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] psc,
  input  logic [CNT_W-1:0] clkl,
  input  logic [CNT_W-1:0] clkh,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             mid_stb,
  output logic             fall_stb
);
  localparam int PH_W = CNT_W + 1;

  typedef enum logic [1:0] {S_LOW, S_WAIT, S_HIGH} ph_t;

  ph_t             st;
  logic            run;
  logic [CNT_W-1:0] pre, psc_q;
  logic [PH_W-1:0]  cnt, low_len, high_len;
  logic [PH_W-1:0]  d_in;

  assign d_in = (psc == '0) ? PH_W'(7) : (psc == CNT_W'(1)) ? PH_W'(6) : PH_W'(5);

  logic tick, last_hi, mid_hit;
  assign tick    = (pre == psc_q);
  assign last_hi = (st == S_HIGH) && tick && (cnt == high_len - 1'b1);
  assign mid_hit = (st == S_HIGH) && tick && ((cnt + 1'b1) == (high_len >> 1));

  assign scl_drive_low = run && (st == S_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      st       <= S_LOW;
      pre      <= '0;
      cnt      <= '0;
      psc_q    <= '0;
      low_len  <= PH_W'(7);
      high_len <= PH_W'(7);
      mid_stb  <= 1'b0;
      fall_stb <= 1'b0;
    end else if (!en || !run) begin
      run      <= en;
      st       <= S_LOW;
      pre      <= '0;
      cnt      <= '0;
      psc_q    <= psc;
      low_len  <= {1'b0, clkl} + d_in;
      high_len <= {1'b0, clkh} + d_in;
      mid_stb  <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      mid_stb  <= mid_hit;
      fall_stb <= last_hi;
      case (st)
        S_LOW: begin
          pre <= tick ? '0 : pre + 1'b1;
          if (tick) begin
            if (cnt == low_len - 1'b1) begin
              st  <= S_WAIT;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_WAIT: begin
          pre <= '0;
          if (scl_in) begin
            st  <= S_HIGH;
            cnt <= '0;
          end
        end
        S_HIGH: begin
          pre <= tick ? '0 : pre + 1'b1;
          if (last_hi) begin
            st       <= S_LOW;
            cnt      <= '0;
            psc_q    <= psc;
            low_len  <= {1'b0, clkl} + d_in;
            high_len <= {1'b0, clkh} + d_in;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_LOW;
      endcase
    end
  end
endmodule

// File: rtl/scl_divgen_chk.sv
module scl_divgen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_in,
  input logic scl_drive_low,
  input logic mid_stb,
  input logic fall_stb
);
  AST_DIS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_drive_low && !mid_stb && !fall_stb); // R7
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb); // R8
  AST_FALL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_drive_low && !$past(scl_drive_low)); // R8
  AST_MID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mid_stb |=> !mid_stb); // R9
  AST_MID_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mid_stb |-> !scl_drive_low && !fall_stb); // R9
  AST_LOW_NOT_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $rose(scl_drive_low)) |-> fall_stb || !$past(en, 2)); // R5
endmodule

bind scl_divgen scl_divgen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .mid_stb(mid_stb), .fall_stb(fall_stb)
);

// File: tb/scl_divgen_tb_top.sv
`timescale 1ns/1ps
module scl_divgen_tb_top;
  logic clk = 0, rst_n = 0, en = 0, scl_in = 1;
  logic [15:0] psc = 0, clkl = 3, clkh = 2;
  logic scl_drive_low, mid_stb, fall_stb;
  int checks = 0, errors = 0;
  int stretch_total = 0, stretch_used = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scl_divgen #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .psc(psc), .clkl(clkl), .clkh(clkh),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .mid_stb(mid_stb), .fall_stb(fall_stb)
  );

  always @(negedge clk) begin
    if (!scl_drive_low && stretch_used < stretch_total) begin
      stretch_used <= stretch_used + 1;
      scl_in <= 1'b0;
    end else begin
      scl_in <= !scl_drive_low;
    end
  end

  function automatic int dval(int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model: remaining cycles per phase
  int mrun = 0, mph = 0, mrem = 0, mel = 0, mP = 1, mL = 7, mH = 7;
  int mmid = 0, mfall = 0;
  always @(posedge clk) begin
    mmid = 0; mfall = 0;
    if (!rst_n) begin
      mrun = 0; mph = 0;
    end else if (!en || mrun == 0) begin
      mP = int'(psc) + 1; mL = int'(clkl) + dval(int'(psc)); mH = int'(clkh) + dval(int'(psc));
      mph = 0; mrem = mL * mP; mrun = en ? 1 : 0;
    end else begin
      case (mph)
        0: begin mrem--; if (mrem == 0) mph = 1; end
        1: if (scl_in) begin mph = 2; mrem = mH * mP; mel = 0; end
        default: begin
          mrem--; mel++;
          if (mel == (mH / 2) * mP) mmid = 1;
          if (mrem == 0) begin
            mP = int'(psc) + 1; mL = int'(clkl) + dval(int'(psc)); mH = int'(clkh) + dval(int'(psc));
            mph = 0; mrem = mL * mP; mfall = 1;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 drive vs model", int'(scl_drive_low), (mrun == 1 && mph == 0) ? 1 : 0);
      chk("R9 mid vs model", int'(mid_stb), mmid);
      chk("R8 fall vs model", int'(fall_stb), mfall);
    end
  end

  task automatic measure(output int lw, output int hw, output int nfall, output int midpos);
    do @(negedge clk); while (scl_drive_low);
    do @(negedge clk); while (!scl_drive_low);
    lw = 0; hw = 0; nfall = 0; midpos = 0;
    while (scl_drive_low) begin
      lw++;
      if (fall_stb) nfall = (lw == 1) ? nfall + 1 : nfall + 100;
      @(negedge clk);
    end
    while (!scl_drive_low) begin
      hw++;
      if (mid_stb) midpos = (midpos == 0) ? hw : -1;
      @(negedge clk);
    end
  endtask

  task automatic run_cfg(input int p, input int l, input int h, input string tg);
    int lw, hw, nf, mp;
    @(negedge clk); en = 0; psc = 16'(p); clkl = 16'(l); clkh = 16'(h);
    @(negedge clk); chk({tg, " R7 released while disabled"}, int'(scl_drive_low), 0);
    en = 1;
    repeat (2) begin
      measure(lw, hw, nf, mp);
      chk({tg, " R3 R4 low width"}, lw, (l + dval(p)) * (p + 1));
      chk({tg, " R5 released width"}, hw, (h + dval(p)) * (p + 1) + 1);
      chk({tg, " R2 low multiple of prescale"}, lw % (p + 1), 0);
      chk({tg, " R8 fall pulse first low cycle"}, nf, 1);
      chk({tg, " R9 mid position"}, mp, 1 + ((h + dval(p)) / 2) * (p + 1) + 1);
    end
  endtask

  initial begin
    int lw, hw, nf, mp;
    repeat (4) @(negedge clk);
    chk("R1 drive in reset", int'(scl_drive_low), 0);
    chk("R1 mid in reset", int'(mid_stb), 0);
    chk("R1 fall in reset", int'(fall_stb), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 drive after reset", int'(scl_drive_low), 0);
    chk("R1 fall after reset", int'(fall_stb), 0);

    run_cfg(0, 3, 2, "psc0");
    run_cfg(1, 2, 4, "psc1");
    run_cfg(3, 1, 0, "psc3");

    // R5 stretch by seven cycles
    do @(negedge clk); while (!scl_drive_low);
    #1 stretch_total = stretch_total + 7;
    while (scl_drive_low) @(negedge clk);
    hw = 0;
    while (!scl_drive_low) begin hw++; @(negedge clk); end
    chk("R5 stretched released width", hw, 5 * 4 + 1 + 7);
    measure(lw, hw, nf, mp);
    chk("R5 width after stretch", hw, 5 * 4 + 1);

    // R7 first low after enable, then R6 change mid-period
    @(negedge clk); en = 0; psc = 0; clkl = 3; clkh = 2;
    @(negedge clk); en = 1;
    @(negedge clk);
    lw = 0;
    while (scl_drive_low) begin lw++; @(negedge clk); end
    chk("R7 first low after enable", lw, 10);
    while (!scl_drive_low) @(negedge clk);
    lw = 0;
    repeat (3) begin lw++; @(negedge clk); end
    clkl = 5; clkh = 6;
    while (scl_drive_low) begin lw++; @(negedge clk); end
    chk("R6 current low unchanged", lw, 10);
    hw = 0;
    while (!scl_drive_low) begin hw++; @(negedge clk); end
    chk("R6 current high unchanged", hw, 10);
    lw = 0;
    while (scl_drive_low) begin lw++; @(negedge clk); end
    chk("R6 next low uses new value", lw, 12);
    hw = 0;
    while (!scl_drive_low) begin hw++; @(negedge clk); end
    chk("R6 next high uses new value", hw, 14);

    // R7 disable in the middle of a low phase
    repeat (4) @(negedge clk);
    chk("R7 low before disable", int'(scl_drive_low), 1);
    en = 0;
    repeat (5) begin
      @(negedge clk);
      chk("R7 released after disable", int'(scl_drive_low), 0);
      chk("R7 strobes quiet when disabled", int'(mid_stb | fall_stb), 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R3 actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule